// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit processor datapath and a word-wide data memory that has one write enable per byte. On the store side it turns an already computed effective address, an access size and a register value into a word address, a four-bit byte write mask and write data with the value placed in the correct lanes. The mask alone decides which lanes update, so the store value is copied into every lane of its size.

On the load side the memory is assumed to be synchronous. It returns the word one cycle after the request. When a load is issued, the block captures the low address bits, the access size and a zero-extend flag. In the following cycle it applies them to the returned word. It picks the addressed byte or halfword, or passes the whole word, and extends it to 32 bits. Byte lanes are big-endian: address offset 0 lives in bits [31:24] and offset 3 in bits [7:0]. Misaligned halfword and word addresses are not trapped. The low bits that do not fit the size are simply ignored.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` always equals `acc_addr[31:2]`, for loads, stores and idle cycles alike.
- R2: When `acc_store` is low, `mem_wmask` is 4'b0000.
- R3: A byte store (`acc_size`=2'b00) sets exactly mask bit 3-k, where k=`acc_addr[1:0]`. `mem_wdata` is `acc_wdata[7:0]` repeated four times.
- R4: A halfword store (`acc_size`=2'b01) gives mask 4'b1100 when `acc_addr[1]`=0 and 4'b0011 when it is 1. `acc_addr[0]` is ignored, and `mem_wdata` is `acc_wdata[15:0]` repeated twice.
- R5: A word store (`acc_size`=2'b10 or the spare code 2'b11) gives mask 4'b1111 and `mem_wdata`=`acc_wdata`, whatever `acc_addr[1:0]` holds.
- R6: `ld_valid` is high exactly in the cycle after a cycle with `acc_load` high. In that cycle `ld_data` is formed from the current `mem_rdata` using the offset, size and flag captured at issue.
- R7: A byte load with `acc_zext`=0 returns the byte at bits [31-8k:24-8k] of `mem_rdata`, sign-extended to 32 bits.
- R8: A byte load with `acc_zext`=1 returns the same byte zero-extended.
- R9: A halfword load with `acc_zext`=0 returns bits [31:16] of `mem_rdata` when the captured `acc_addr[1]`=0 and bits [15:0] when it is 1, sign-extended. Bit 0 is ignored.
- R10: A halfword load with `acc_zext`=1 returns the same halfword zero-extended.
- R11: A word load (size 2'b10 or 2'b11) returns `mem_rdata` unchanged, and `acc_zext` has no effect.
- R12: In cycles without `acc_load`, the captured offset, size and flag are held. `ld_data` keeps extracting from `mem_rdata` with the last captured load's settings.
- R13: During reset and until the first load, `ld_valid` is 0 and `ld_data` equals `mem_rdata`, because the captured settings reset to word size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 32 | Effective byte address of the access |
| acc_store | input | 1 | Store request this cycle |
| acc_load | input | 1 | Load request this cycle |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_zext | input | 1 | Load result is zero-extended when high |
| acc_wdata | input | 32 | Register value to store |
| mem_addr | output | 30 | Word address to the memory |
| mem_wmask | output | 4 | Per-byte write enable, bit 3 is bits [31:24] |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Word returned by memory one cycle after a load |
| ld_valid | output | 1 | Load result valid this cycle |
| ld_data | output | 32 | Extracted and extended load result |

## Verification
Every cycle, the assertions check the store mask population for each size, the zero mask when no store is active, and the lane replication of byte store data. They also check the one-cycle load valid timing, and the extension bits and word pass-through on the cycle after a load issue. The exact lane chosen for each offset, the big-endian ordering, the ignoring of unused low address bits, and the holding of captured settings across idle cycles are shown only by the bench. The bench's reference model recomputes every output each cycle, using directed offset sweeps followed by random traffic.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int OFS_W  = $clog2(LANES);
  localparam int HALVES = LANES / 2;
  localparam int HIDX_W = OFS_W - 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_SPARE = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic [OFS_W-1:0] ofs;
    acc_size_e        size;
    logic             zext;
  } ld_ctx_t;
endpackage

// File: rtl/lsu_rst_sync.sv
module lsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
  import lsu_align_pkg::*;
(
  input  logic              store_en,
  input  logic [OFS_W-1:0]  ofs,
  input  acc_size_e         size,
  input  logic [WORD_W-1:0] wdata,
  output logic [LANES-1:0]  wmask,
  output logic [WORD_W-1:0] wdata_lanes
);
  localparam int HALF_W = WORD_W / 2;

  always_comb begin
    unique case (size)
      SZ_BYTE: wdata_lanes = {LANES{wdata[LANE_W-1:0]}};
      SZ_HALF: wdata_lanes = {HALVES{wdata[HALF_W-1:0]}};
      default: wdata_lanes = wdata;
    endcase
  end

  // lane i holds bits [LANE_W*i +: LANE_W]; its byte offset is LANES-1-i
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_OFS = OFS_W'(LANES - 1 - i);
    logic hit;
    always_comb begin
      unique case (size)
        SZ_BYTE: hit = (ofs == LANE_OFS);
        SZ_HALF: hit = (ofs[OFS_W-1:1] == LANE_OFS[OFS_W-1:1]);
        default: hit = 1'b1;
      endcase
    end
    assign wmask[i] = store_en & hit;
  end
endmodule

// File: rtl/lsu_load_ctx.sv
module lsu_load_ctx
  import lsu_align_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_en,
  input  ld_ctx_t ctx_d,
  output ld_ctx_t ctx_q,
  output logic    valid_q
);
  localparam ld_ctx_t CTX_RST = '{ofs: '0, size: SZ_WORD, zext: 1'b0};

  ld_ctx_t ctx_nxt;
  logic    valid_nxt;

  always_comb begin
    ctx_nxt   = ctx_q;
    valid_nxt = load_en;
    if (load_en) begin
      ctx_nxt = ctx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q   <= CTX_RST;
      valid_q <= 1'b0;
    end else begin
      ctx_q   <= ctx_nxt;
      valid_q <= valid_nxt;
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
(
  input  ld_ctx_t           ctx,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] ld_data
);
  localparam int HALF_W = WORD_W / 2;
  localparam logic [OFS_W-1:0]  BYTE_MAX = OFS_W'(LANES - 1);
  localparam logic [HIDX_W-1:0] HALF_MAX = HIDX_W'(HALVES - 1);

  logic [LANE_W-1:0] lane_b [LANES];
  logic [HALF_W-1:0] lane_h [HALVES];

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign lane_b[i] = rdata[LANE_W*i +: LANE_W];
  end
  for (genvar j = 0; j < HALVES; j++) begin : g_half
    assign lane_h[j] = rdata[HALF_W*j +: HALF_W];
  end

  logic [OFS_W-1:0]  byte_idx;
  logic [HIDX_W-1:0] half_idx;
  logic [LANE_W-1:0] byte_sel;
  logic [HALF_W-1:0] half_sel;

  always_comb begin
    byte_idx = BYTE_MAX - ctx.ofs;
    half_idx = HALF_MAX - ctx.ofs[OFS_W-1:1];
    byte_sel = lane_b[byte_idx];
    half_sel = lane_h[half_idx];
    unique case (ctx.size)
      SZ_BYTE: ld_data = ctx.zext ? {{(WORD_W-LANE_W){1'b0}}, byte_sel}
                                  : {{(WORD_W-LANE_W){byte_sel[LANE_W-1]}}, byte_sel};
      SZ_HALF: ld_data = ctx.zext ? {{(WORD_W-HALF_W){1'b0}}, half_sel}
                                  : {{(WORD_W-HALF_W){half_sel[HALF_W-1]}}, half_sel};
      default: ld_data = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic                    acc_store,
  input  logic                    acc_load,
  input  logic [1:0]              acc_size,
  input  logic                    acc_zext,
  input  logic [WORD_W-1:0]       acc_wdata,
  output logic [ADDR_W-OFS_W-1:0] mem_addr,
  output logic [LANES-1:0]        mem_wmask,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    ld_valid,
  output logic [WORD_W-1:0]       ld_data
);
  logic      rst_n_int;
  acc_size_e size_e;
  ld_ctx_t   ctx_in;
  ld_ctx_t   ctx_held;

  assign size_e   = acc_size_e'(acc_size);
  assign mem_addr = acc_addr[ADDR_W-1:OFS_W];
  assign ctx_in   = '{ofs: acc_addr[OFS_W-1:0], size: size_e, zext: acc_zext};

  lsu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lsu_store_pack u_store_pack (
    .store_en    (acc_store),
    .ofs         (acc_addr[OFS_W-1:0]),
    .size        (size_e),
    .wdata       (acc_wdata),
    .wmask       (mem_wmask),
    .wdata_lanes (mem_wdata)
  );

  lsu_load_ctx u_load_ctx (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_en (acc_load),
    .ctx_d   (ctx_in),
    .ctx_q   (ctx_held),
    .valid_q (ld_valid)
  );

  lsu_load_extract u_load_extract (
    .ctx     (ctx_held),
    .rdata   (mem_rdata),
    .ld_data (ld_data)
  );
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        acc_store,
  input logic        acc_load,
  input logic [1:0]  acc_size,
  input logic        acc_zext,
  input logic [31:0] acc_wdata,
  input logic [3:0]  mem_wmask,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata,
  input logic        ld_valid,
  input logic [31:0] ld_data
);
  assert_idle_mask_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !acc_store |-> mem_wmask == 4'b0000);

  assert_byte_mask_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_store && acc_size == 2'b00 |-> $countones(mem_wmask) == 1);

  assert_byte_repl_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_store && acc_size == 2'b00 |-> mem_wdata == {4{acc_wdata[7:0]}});

  assert_half_mask_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_store && acc_size == 2'b01 |-> (mem_wmask == 4'b1100 || mem_wmask == 4'b0011));

  assert_word_mask_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_store && acc_size[1] |-> mem_wmask == 4'b1111);

  assert_valid_next_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_load |=> ld_valid);

  assert_valid_only_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    !acc_load |=> !ld_valid);

  assert_byte_sext_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_load && acc_size == 2'b00 && !acc_zext |=> ld_data[31:8] == {24{ld_data[7]}});

  assert_byte_zext_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_load && acc_size == 2'b00 && acc_zext |=> ld_data[31:8] == 24'h0);

  assert_half_sext_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_load && acc_size == 2'b01 && !acc_zext |=> ld_data[31:16] == {16{ld_data[15]}});

  assert_half_zext_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_load && acc_size == 2'b01 && acc_zext |=> ld_data[31:16] == 16'h0);

  assert_word_pass_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_load && acc_size[1] |=> ld_data == mem_rdata);
endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_int),
  .acc_store (acc_store),
  .acc_load  (acc_load),
  .acc_size  (acc_size),
  .acc_zext  (acc_zext),
  .acc_wdata (acc_wdata),
  .mem_wmask (mem_wmask),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .ld_valid  (ld_valid),
  .ld_data   (ld_data)
);

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] acc_addr;
  logic        acc_store;
  logic        acc_load;
  logic [1:0]  acc_size;
  logic        acc_zext;
  logic [31:0] acc_wdata;
  logic [29:0] mem_addr;
  logic [3:0]  mem_wmask;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        ld_valid;
  logic [31:0] ld_data;

  int tests;
  int fails;

  // reference model state: what the last issued load asked for
  int   m_ofs;
  int   m_size;
  bit   m_zext;
  bit   m_valid;
  bit   m_seen_load;

  lsu_lane_align u_lsu_lane_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_addr  (acc_addr),
    .acc_store (acc_store),
    .acc_load  (acc_load),
    .acc_size  (acc_size),
    .acc_zext  (acc_zext),
    .acc_wdata (acc_wdata),
    .mem_addr  (mem_addr),
    .mem_wmask (mem_wmask),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .ld_valid  (ld_valid),
    .ld_data   (ld_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_mask(bit st, int size, int ofs);
    if (!st) return 4'b0000;
    if (size == 0) return 4'(1 << (3 - ofs));
    if (size == 1) return (ofs >= 2) ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] ref_wdata(int size, logic [31:0] v);
    if (size == 0) return {v[7:0], v[7:0], v[7:0], v[7:0]};
    if (size == 1) return {v[15:0], v[15:0]};
    return v;
  endfunction

  function automatic logic [31:0] ref_load(int size, bit zx, int ofs, logic [31:0] w);
    logic [31:0] b;
    logic [31:0] h;
    b = (w >> (8 * (3 - ofs))) & 32'hFF;
    h = (w >> (16 * (1 - ofs / 2))) & 32'hFFFF;
    if (size == 0) return (zx || !b[7]) ? b : (b | 32'hFFFF_FF00);
    if (size == 1) return (zx || !h[15]) ? h : (h | 32'hFFFF_0000);
    return w;
  endfunction

  function automatic string load_tag(int size, bit zx, bit seen, bit valid);
    if (!seen) return "R13";
    if (!valid) return "R12";
    if (size == 0) return zx ? "R8" : "R7";
    if (size == 1) return zx ? "R10" : "R9";
    return "R11";
  endfunction

  function automatic string store_tag(bit st, int size);
    if (!st) return "R2";
    if (size == 0) return "R3";
    if (size == 1) return "R4";
    return "R5";
  endfunction

  // one clock: drive at negedge, compare away from the edge, then advance the model
  task automatic cyc(bit st, bit ld, logic [31:0] addr, int size, bit zx,
                     logic [31:0] wd, logic [31:0] rd);
    @(negedge clk);
    acc_store = st;
    acc_load  = ld;
    acc_addr  = addr;
    acc_size  = 2'(size);
    acc_zext  = zx;
    acc_wdata = wd;
    mem_rdata = rd;
    #1;
    chk("R1", {2'b00, mem_addr}, {2'b00, addr[31:2]});
    chk(store_tag(st, size), {28'h0, mem_wmask}, {28'h0, ref_mask(st, size, int'(addr[1:0]))});
    if (st) chk(store_tag(st, size), mem_wdata, ref_wdata(size, wd));
    chk("R6", {31'h0, ld_valid}, {31'h0, m_valid});
    chk(load_tag(m_size, m_zext, m_seen_load, m_valid), ld_data,
        ref_load(m_size, m_zext, m_ofs, rd));
    @(posedge clk);
    m_valid = ld;
    if (ld) begin
      m_ofs = int'(addr[1:0]);
      m_size = size;
      m_zext = zx;
      m_seen_load = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0;
    fails = 0;
    m_ofs = 0;
    m_size = 2;
    m_zext = 1'b0;
    m_valid = 1'b0;
    m_seen_load = 1'b0;
    rst_n = 1'b0;
    acc_store = 1'b0;
    acc_load = 1'b0;
    acc_addr = 32'h0;
    acc_size = 2'b00;
    acc_zext = 1'b0;
    acc_wdata = 32'h0;
    mem_rdata = 32'hCAFE_F00D;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13", {31'h0, ld_valid}, 32'h0);
    chk("R13", ld_data, 32'hCAFE_F00D);
    chk("R2", {28'h0, mem_wmask}, 32'h0);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 32'h0000_0010, 0, 0, 32'h0, 32'h1234_5678);

    // byte stores and byte loads over every offset, both extensions
    for (int k = 0; k < 4; k++) begin
      cyc(1, 0, 32'h1000_0000 + 32'(k), 0, 0, 32'hAABB_CC5A, 32'h0);
      cyc(0, 1, 32'h2000_0000 + 32'(k), 0, 0, 32'h0, 32'h0);
      cyc(0, 1, 32'h2000_0000 + 32'(k), 0, 1, 32'h0, 32'h807F_01FE);
      cyc(0, 0, 32'h0, 0, 0, 32'h0, 32'h807F_01FE);
    end
    // halfword stores and loads, including odd low bit
    for (int k = 0; k < 4; k++) begin
      cyc(1, 0, 32'h3000_0000 + 32'(k), 1, 0, 32'h1111_9A7C, 32'h0);
      cyc(0, 1, 32'h3000_0000 + 32'(k), 1, 0, 32'h0, 32'h0);
      cyc(0, 1, 32'h3000_0000 + 32'(k), 1, 1, 32'h0, 32'h8001_7FFF);
      cyc(0, 0, 32'h0, 0, 0, 32'h0, 32'h7FFF_8001);
    end
    // word stores and loads with every low-bit pattern and the spare size
    for (int k = 0; k < 4; k++) begin
      cyc(1, 0, 32'hFFFF_FFF0 + 32'(k), 2 + (k & 1), 0, 32'hDEAD_BEEF, 32'h0);
      cyc(0, 1, 32'h4000_0000 + 32'(k), 2 + (k & 1), k[1], 32'h0, 32'h0);
      cyc(0, 0, 32'h0, 0, 0, 32'h0, 32'h8765_4321);
    end
    // held settings across idle cycles with changing read data
    cyc(0, 1, 32'h5000_0002, 0, 1, 32'h0, 32'h0);
    cyc(0, 0, 32'h5000_0001, 1, 0, 32'h0, 32'h00FF_0000);
    cyc(0, 0, 32'h5000_0003, 2, 0, 32'h0, 32'hFF00_80FF);
    cyc(1, 0, 32'h5000_0000, 2, 0, 32'h0102_0304, 32'h0000_9900);
    // back-to-back loads and a store alongside a load
    cyc(1, 1, 32'h6000_0001, 0, 0, 32'h0000_0081, 32'h0);
    cyc(0, 1, 32'h6000_0002, 1, 0, 32'h0, 32'h1122_8844);
    cyc(0, 0, 32'h0, 0, 0, 32'h0, 32'hF0E1_D2C3);
    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[1], $urandom, int'(r[3:2]), r[4], $urandom, $urandom);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule